// File: doc/BRIEF.md
# NOR Flash Single-Word Program Sequencer

This block writes one bus-width word into a parallel NOR flash device and then confirms that the write finished. A requester presents a target address and a datum with a valid/ready handshake. The sequencer then owns the flash bus. It issues the three-cycle unlock-and-program command, writes the datum to the target address and stays off the bus for a caller-supplied number of cycles, the typical program time. After that it reads the target address once per cycle until two consecutive reads agree, which shows that the device's status toggling has stopped.

The settled value is compared with the datum. On a match the block returns to ready with no error. On a mismatch, or when the read budget runs out before the data settles, it writes the device's reset command and raises an error flag. A second flag marks the case where the read budget ran out. Both flags hold until the next request is accepted. The flash bus uses one-cycle strobes. A write cycle has `fl_we` high with address and data valid. A read cycle has `fl_oe` high, and `fl_din` is captured at the clock edge that ends that cycle.

The sequencer moves through these states: READY (0), UNLOCK_A (1), UNLOCK_B (2), PROGRAM_CMD (3), DATUM (4), SETTLE_WAIT (5), POLL (6), VERIFY (7) and ABORT (8). The transitions are as follows:
- READY goes to UNLOCK_A on an accepted request.
- UNLOCK_A, UNLOCK_B and PROGRAM_CMD each advance unconditionally.
- DATUM goes to POLL when the program time is zero, and to SETTLE_WAIT otherwise.
- SETTLE_WAIT goes to POLL when its timer expires.
- POLL goes to VERIFY when the data has settled, and to ABORT when the read limit is hit.
- VERIFY goes to READY on a match and to ABORT on a mismatch.
- ABORT goes to READY.

Top module: `nor_word_prog`

## Requirements
- R1: `req_ready` is high only in READY (state code 0). A request is accepted only when `req_valid` and `req_ready` are both high. A `req_valid` pulse while busy has no effect on the bus sequence, and no bus activity follows it once the block is back in READY.
- R2: After acceptance, the block issues four write cycles on consecutive clocks: data 0xAA to address 0x5555, data 0x55 to address 0x2AAA, data 0xA0 to address 0x5555, then the datum to the target address.
- R3: Between the datum write cycle and the first read cycle there are exactly `prog_cycles` clock cycles with neither strobe asserted.
- R4: Every poll read is at the target address, one per cycle. At least three reads are made. Polling ends at the first read n (n >= 3) whose value equals that of read n-1.
- R5: The total number of poll reads never exceeds POLL_LIMIT (default 10000). If the limit is reached without settling, the block writes 0xF0 to address 0 and sets both `err` and `err_timeout`. Settling on exactly the last allowed read counts as success.
- R6: If the settled value equals the datum, the block returns to READY with `err` and `err_timeout` low and issues no further write.
- R7: If the settled value differs from the datum, the block writes 0xF0 to address 0, then returns to READY with `err` high and `err_timeout` low.
- R8: `err` and `err_timeout` keep their value while the block is in READY and read low in the cycle after a request is accepted.
- R9: `busy` is always the inverse of `req_ready`. `state_code` shows 1 in the cycle after acceptance, 4 during the datum write and 6 during poll reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| prog_cycles | input | TW | Typical program time in clock cycles, latched at acceptance |
| busy | output | 1 | Operation in progress |
| state_code | output | 4 | Current sequencer state |
| err | output | 1 | Last operation failed |
| err_timeout | output | 1 | Last failure was a read-limit expiry |
| fl_addr | output | AW | Flash address |
| fl_dout | output | DW | Flash write data |
| fl_we | output | 1 | Flash write cycle strobe |
| fl_oe | output | 1 | Flash read cycle strobe |
| fl_din | input | DW | Flash read data |

## Verification
Settle detection and read-limit expiry can occur on the same poll read. The bench arranges this with a flash model that toggles for exactly POLL_LIMIT-2 reads, so the second stable sample lands on the last allowed read; the expected result is success with no reset write. A companion case toggles for POLL_LIMIT-1 reads, so the first stable sample arrives on the last read, and this must end as a timeout with the 0xF0 write. A request pulse arriving mid-operation is also checked: it must leave both the bus sequence and the idle period afterwards untouched.

// File: rtl/nor_wp_pkg.sv
package nor_wp_pkg;

    typedef enum logic [3:0] {
        ST_READY       = 4'd0,
        ST_UNLK_A      = 4'd1,
        ST_UNLK_B      = 4'd2,
        ST_PGM_CMD     = 4'd3,
        ST_DATUM       = 4'd4,
        ST_SETTLE_WAIT = 4'd5,
        ST_POLL        = 4'd6,
        ST_VERIFY      = 4'd7,
        ST_ABORT       = 4'd8
    } wp_state_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [15:0] CODE_UNLOCK_A = 16'h00AA;
    localparam logic [15:0] CODE_UNLOCK_B = 16'h0055;
    localparam logic [15:0] CODE_PROGRAM  = 16'h00A0;
    localparam logic [15:0] CODE_RESET    = 16'h00F0;

endpackage

// File: rtl/nor_bus_drive.sv
module nor_bus_drive
    import nor_wp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  wp_state_e         state,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_we,
    output logic              bus_oe
);

    always_comb begin
        bus_addr = '0;
        bus_dout = '0;
        bus_we   = 1'b0;
        bus_oe   = 1'b0;
        unique case (state)
            ST_UNLK_A: begin
                bus_we   = 1'b1;
                bus_addr = AW'(UNLOCK_ADDR_A);
                bus_dout = DW'(CODE_UNLOCK_A);
            end
            ST_UNLK_B: begin
                bus_we   = 1'b1;
                bus_addr = AW'(UNLOCK_ADDR_B);
                bus_dout = DW'(CODE_UNLOCK_B);
            end
            ST_PGM_CMD: begin
                bus_we   = 1'b1;
                bus_addr = AW'(UNLOCK_ADDR_A);
                bus_dout = DW'(CODE_PROGRAM);
            end
            ST_DATUM: begin
                bus_we   = 1'b1;
                bus_addr = tgt_addr;
                bus_dout = tgt_data;
            end
            ST_POLL: begin
                bus_oe   = 1'b1;
                bus_addr = tgt_addr;
            end
            ST_ABORT: begin
                bus_we   = 1'b1;
                bus_addr = '0;
                bus_dout = DW'(CODE_RESET);
            end
            default: begin
                bus_we   = 1'b0;
                bus_oe   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          expired
);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (run && remain != '0) begin
            remain <= remain - TW'(1);
        end
    end

    assign expired = (remain == '0);

    // R3: the countdown never moves while a new load is absent and it is idle at zero
    a_r3_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(remain) == '0 && $past(!load)) |-> remain == '0);

endmodule

// File: rtl/nor_toggle_poll.sv
module nor_toggle_poll #(
    parameter int DW    = 16,
    parameter int LIMIT = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] latest,
    output logic          settled,
    output logic          limit_hit
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken  <= '0;
            latest <= '0;
        end else if (clear) begin
            taken  <= '0;
        end else if (sample) begin
            taken  <= taken + CW'(1);
            latest <= rdata;
        end
    end

    // a read settles when it is at least the third and repeats its predecessor
    assign settled   = sample && (taken >= CW'(2)) && (rdata == latest);
    assign limit_hit = sample && (taken == CW'(LIMIT - 1));

    // R5: no read is ever issued beyond the budget
    a_r5_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> taken < CW'(LIMIT));

    // R4: a counted read moves the tally by exactly one
    a_r4_one_per_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clear) |=> taken == $past(taken) + CW'(1));

endmodule

// File: rtl/nor_word_prog.sv
module nor_word_prog
    import nor_wp_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int TW         = 16,
    parameter int POLL_LIMIT = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [TW-1:0] prog_cycles,
    output logic          busy,
    output logic [3:0]    state_code,
    output logic          err,
    output logic          err_timeout,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    output logic          fl_we,
    output logic          fl_oe,
    input  logic [DW-1:0] fl_din
);

    wp_state_e     state, nxt;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic [TW-1:0] prog_q;
    logic          timeout_q;
    logic          accept;
    logic          tmr_expired;
    logic [DW-1:0] poll_latest;
    logic          poll_settled;
    logic          poll_limit;

    assign accept = req_valid && req_ready;

    nor_bus_drive #(.AW(AW), .DW(DW)) u_drive (
        .state    (state),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .bus_addr (fl_addr),
        .bus_dout (fl_dout),
        .bus_we   (fl_we),
        .bus_oe   (fl_oe)
    );

    nor_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_DATUM),
        .load_val (prog_q - TW'(1)),
        .run      (state == ST_SETTLE_WAIT),
        .expired  (tmr_expired)
    );

    nor_toggle_poll #(.DW(DW), .LIMIT(POLL_LIMIT)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_DATUM),
        .sample    (fl_oe),
        .rdata     (fl_din),
        .latest    (poll_latest),
        .settled   (poll_settled),
        .limit_hit (poll_limit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READY:       if (req_valid) nxt = ST_UNLK_A;
            ST_UNLK_A:      nxt = ST_UNLK_B;
            ST_UNLK_B:      nxt = ST_PGM_CMD;
            ST_PGM_CMD:     nxt = ST_DATUM;
            ST_DATUM:       nxt = (prog_q == '0) ? ST_POLL : ST_SETTLE_WAIT;
            ST_SETTLE_WAIT: if (tmr_expired) nxt = ST_POLL;
            ST_POLL: begin
                if (poll_settled)    nxt = ST_VERIFY;
                else if (poll_limit) nxt = ST_ABORT;
            end
            ST_VERIFY:      nxt = (poll_latest == tgt_data) ? ST_READY : ST_ABORT;
            ST_ABORT:       nxt = ST_READY;
            default:        nxt = ST_READY;
        endcase
    end

    // registered outputs and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_addr    <= '0;
            tgt_data    <= '0;
            prog_q      <= '0;
            timeout_q   <= 1'b0;
            err         <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            if (accept) begin
                tgt_addr    <= req_addr;
                tgt_data    <= req_data;
                prog_q      <= prog_cycles;
                timeout_q   <= 1'b0;
                err         <= 1'b0;
                err_timeout <= 1'b0;
            end
            if (state == ST_POLL && !poll_settled && poll_limit) begin
                timeout_q <= 1'b1;
            end
            if (state == ST_ABORT) begin
                err         <= 1'b1;
                err_timeout <= timeout_q;
            end
        end
    end

    assign req_ready  = (state == ST_READY);
    assign busy       = (state != ST_READY);
    assign state_code = state;

    // R1: an idle block leaves the flash bus quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!fl_we && !fl_oe));

    // R2: the second unlock cycle is preceded by the first unlock write
    a_r2_unlock_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNLK_B) |-> ($past(fl_we) && $past(fl_dout) == DW'(CODE_UNLOCK_A)
                                  && $past(fl_addr) == AW'(UNLOCK_ADDR_A)));

    // R3: nothing moves on the bus while the program time elapses
    a_r3_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE_WAIT) |-> (!fl_we && !fl_oe));

    // R7: an error only appears right after the reset command write
    a_r7_reset_before_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(fl_we) && $past(fl_dout) == DW'(CODE_RESET) && $past(fl_addr) == '0));

    // R8: acceptance clears the error flags on the next cycle
    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!err && !err_timeout));

    // R8: flags hold while idle without a request
    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> (err == $past(err) && err_timeout == $past(err_timeout)));

    // R5: a timeout is never reported without an error
    a_r5_timeout_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> err);

endmodule

// File: tb/nor_word_prog_bench.sv
module nor_word_prog_bench;

    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int TW  = 8;
    localparam int LIM = 10000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [TW-1:0] prog_cycles = '0;
    logic          busy;
    logic [3:0]    state_code;
    logic          err, err_timeout;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dout;
    logic          fl_we, fl_oe;
    logic [DW-1:0] fl_din;

    always #5 clk = ~clk;

    nor_word_prog #(.AW(AW), .DW(DW), .TW(TW), .POLL_LIMIT(LIM)) u_nor_word_prog (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .prog_cycles(prog_cycles),
        .busy(busy), .state_code(state_code), .err(err), .err_timeout(err_timeout),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_we(fl_we), .fl_oe(fl_oe), .fl_din(fl_din)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // flash model: toggles for cfg_k reads after the datum write, then returns the stored word
    int            cfg_k = 0;
    bit            cfg_corrupt = 0;
    int            wseen = 0;
    int            busy_left = 0;
    logic          tog = 1'b0;
    logic [DW-1:0] stored = '0;

    assign fl_din = (busy_left > 0) ? {8'h00, ~stored[7], tog, 6'h00} : stored;

    always @(posedge clk) begin
        if (req_valid && req_ready) wseen <= 0;
        else if (fl_we) wseen <= wseen + 1;
        if (fl_we && wseen == 3) begin
            busy_left <= cfg_k;
            stored    <= cfg_corrupt ? (fl_dout ^ 16'h0001) : fl_dout;
        end else if (fl_oe && busy_left > 0) begin
            busy_left <= busy_left - 1;
            tog       <= ~tog;
        end
    end

    // bus monitor
    int            wr_n, rd_n, rd_first, st_first, st_datum;
    logic [AW-1:0] wr_addr [8];
    logic [DW-1:0] wr_data [8];
    int            wr_cyc  [8];
    logic [AW-1:0] exp_addr;
    bit            rd_badaddr, bad_busy, bad_both;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy !== !req_ready) bad_busy = 1;
            if (fl_we && fl_oe) bad_both = 1;
            if (fl_we) begin
                if (wr_n < 8) begin
                    wr_addr[wr_n] = fl_addr;
                    wr_data[wr_n] = fl_dout;
                    wr_cyc[wr_n]  = cyc;
                    if (wr_n == 3) st_datum = int'(state_code);
                end
                wr_n++;
            end
            if (fl_oe) begin
                if (rd_n == 0) begin
                    rd_first = cyc;
                    st_first = int'(state_code);
                end
                if (fl_addr !== exp_addr) rd_badaddr = 1;
                rd_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_timeout(input int k);
        return (k + 2) > LIM;
    endfunction

    function automatic int exp_reads(input int k);
        if (exp_timeout(k)) return LIM;
        return (k + 2 < 3) ? 3 : k + 2;
    endfunction

    task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int pt, input int k, input bit corrupt, input bit poke);
        bit to, e;
        int hold_w, hold_r;
        logic hold_err;
        cfg_k = k;
        cfg_corrupt = corrupt;
        while (!req_ready) @(negedge clk);
        wr_n = 0; rd_n = 0; rd_first = 0; st_first = -1; st_datum = -1;
        rd_badaddr = 0; exp_addr = a;
        req_addr = a; req_data = d; prog_cycles = TW'(pt); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!err && !err_timeout, "R8", "flags after accept", {err, err_timeout}, 0);
        chk(busy && state_code == 4'd1, "R9", "state after accept", state_code, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            req_addr = ~a; req_data = ~d; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!req_ready) @(negedge clk);
        to = exp_timeout(k);
        e  = to || corrupt;
        chk(wr_n == 4 + int'(e), "R2", "write count", wr_n, 4 + int'(e));
        chk(wr_addr[0] == 16'h5555 && wr_data[0] == 16'h00AA, "R2", "unlock A", wr_data[0], 16'h00AA);
        chk(wr_addr[1] == 16'h2AAA && wr_data[1] == 16'h0055, "R2", "unlock B", wr_data[1], 16'h0055);
        chk(wr_addr[2] == 16'h5555 && wr_data[2] == 16'h00A0, "R2", "program code", wr_data[2], 16'h00A0);
        chk(wr_addr[3] == a && wr_data[3] == d, "R2", "datum write", wr_data[3], d);
        chk(wr_cyc[3] - wr_cyc[0] == 3, "R2", "consecutive writes", wr_cyc[3] - wr_cyc[0], 3);
        chk(rd_first - wr_cyc[3] - 1 == pt, "R3", "idle gap", rd_first - wr_cyc[3] - 1, pt);
        chk(rd_n == exp_reads(k), "R4", "read count", rd_n, exp_reads(k));
        chk(!rd_badaddr, "R4", "read address", rd_badaddr, 0);
        chk(st_datum == 4 && st_first == 6, "R9", "state codes", st_first, 6);
        if (e) chk(wr_addr[4] == '0 && wr_data[4] == 16'h00F0, "R7", "reset write", wr_data[4], 16'h00F0);
        chk(err == e, to ? "R5" : (corrupt ? "R7" : "R6"), "err", err, e);
        chk(err_timeout == to, "R5", "err_timeout", err_timeout, to);
        hold_w = wr_n; hold_r = rd_n; hold_err = err;
        repeat (3) @(negedge clk);
        chk(wr_n == hold_w && rd_n == hold_r, "R1", "bus quiet in ready", wr_n, hold_w);
        chk(err == hold_err, "R8", "err held", err, hold_err);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        wr_n = 0; rd_n = 0; bad_busy = 0; bad_both = 0; exp_addr = '0;
        repeat (3) @(negedge clk);
        chk(!busy && state_code == 4'd0 && !err && !err_timeout && !fl_we && !fl_oe,
            "R9", "reset state", state_code, 0);
        chk(req_ready, "R1", "ready at reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(16'h1234, 16'hBEEF, 0, 0, 0, 0);    // immediate settle, no wait
        run_op(16'h0042, 16'h00FF, 1, 1, 0, 1);    // late request pulse ignored
        run_op(16'h7777, 16'h5A5A, 5, 6, 1, 0);    // mismatch after settling
        run_op(16'h0001, 16'h0002, 2, 3, 0, 0);    // error cleared by new request
        run_op(16'hABCD, 16'h1357, 255, 2, 0, 0);  // long wait
        run_op(16'h2000, 16'hCAFE, 3, LIM - 2, 0, 0); // R5 settles on last allowed read
        run_op(16'h2001, 16'hCAFE, 3, LIM - 1, 0, 0); // R5 limit hit on first stable read
        run_op(16'h2002, 16'hF00D, 0, 1 << 30, 0, 0); // R5 device never settles

        for (int i = 0; i < 40; i++) begin
            run_op(AW'($urandom), DW'($urandom), int'($urandom_range(0, 15)),
                   int'($urandom_range(0, 20)), ($urandom_range(0, 4) == 0), ($urandom_range(0, 3) == 0));
        end

        chk(!bad_busy, "R9", "busy inverse of ready", bad_busy, 0);
        chk(!bad_both, "R1", "no simultaneous strobes", bad_both, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule